// File: doc/BRIEF.md
# Burst SRAM Command Scheduler

This block sits on the host side of a two-word-burst DDR SRAM and turns a stream of user requests into memory commands. Each request names a direction, an address, two write words and a tag. The scheduler places it into the next free memory slot and drives the command, the address and the two write words. Every command moves a two-word burst, one word per half of the memory clock.

Time is counted on a tick clock that runs at twice the memory clock, so one memory slot is two ticks and a half-cycle latency is a whole number of ticks. The scheduler gives back-to-back slots to write-write, write-read and read-read pairs. When a write follows a read it holds the write back for two idle slots, or three when the extra turnaround bit is set. It also predicts when read data comes back, either 2.5 memory cycles or one cycle after the read when the slow-latency mode is selected. It raises an early flag one tick before the first word and flags both words with the tag of the oldest outstanding read.

Outstanding read tags are kept in a small first-in first-out store. The scheduler stops taking requests while that store is full.

Top module: `sram_burst_sched`

## Requirements
- R1: A request is taken on a rising edge where reqValid and reqReady are both high. reqReady is only ever high in the second tick of a memory slot. The taken request appears on memCmd (0 = idle, 1 = read, 2 = write) together with memAddr for both ticks of the next slot. Any slot without a taken request shows 0.
- R2: Between a read slot and the next write slot there are at least 2 idle slots, or at least 3 when cfgExtraNop is 1. A write that arrives earlier sees reqReady low until enough idle slots have passed, so it issues exactly 6 ticks (8 ticks with cfgExtraNop) after the read when requested at once.
- R3: Write after write, read after write and read after read issue in consecutive slots, 2 ticks apart.
- R4: In a write slot memWdataValid is high for both ticks. memWdata carries reqWdata[DATA_W-1:0] in the first tick and reqWdata[2*DATA_W-1:DATA_W] in the second tick.
- R5: With cfgSlowLat at 0, rdValid is high in ticks 5 and 6 counted from the first tick of the read slot (tick 0), and rdLast is high in tick 6 only.
- R6: With cfgSlowLat at 1, the two words are flagged in ticks 2 and 3, with rdLast in tick 3. cfgSlowLat and cfgExtraNop change only while no read is outstanding.
- R7: rdEarly is high for the single tick just before the first word of each read.
- R8: Read tags come back in the order the reads were taken. rdTag shows the tag of the read whose words are flagged while rdValid is high.
- R9: At most TAG_DEPTH reads are outstanding. A read counts from when it is taken until the tick of its rdLast. reqReady stays low while TAG_DEPTH reads are outstanding.
- R10: While rstN is low, memCmd is 0 and rdValid and reqReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rstN | input | 1 | Synchronous active-low reset |
| cfgExtraNop | input | 1 | Adds a third idle slot in the read-to-write turnaround |
| cfgSlowLat | input | 1 | Selects the one-cycle read latency |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | The request is taken at this edge if reqValid is high |
| reqWrite | input | 1 | 1 for a write request, 0 for a read |
| reqAddr | input | ADDR_W | Burst address |
| reqWdata | input | 2*DATA_W | Both write words, first word in the low half |
| reqTag | input | TAG_W | Tag returned with the read data |
| memCmd | output | 2 | Memory command: 0 idle, 1 read, 2 write |
| memAddr | output | ADDR_W | Address of the current command |
| memWdata | output | DATA_W | Write word for this tick |
| memWdataValid | output | 1 | memWdata carries a write word |
| rdEarly | output | 1 | Read data starts on the next tick |
| rdValid | output | 1 | A read word arrives in this tick |
| rdLast | output | 1 | This is the second word of the burst |
| rdTag | output | TAG_W | Tag of the read being returned |

## Verification
The assertions check the slot rules on every tick. They check that the command holds for both ticks of its slot, that the handshake is only open in the second tick, and that the idle-slot count between a read and a following write meets the configured bubble. They also check that the early flag comes before each first word, that a last word follows a first word, and that the outstanding read count never exceeds the tag store. The actual latency in ticks, the word order inside a write burst, the tag order, and the stall caused by a full tag store at exactly the right tick are shown only by the bench's scenarios. These scenarios cover both latency modes and both turnaround settings, and they compare each result with a tick number worked out beforehand.

// File: rtl/sram_sched_pkg.sv
package sram_sched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } memCmdE;

  // strobes from control to datapath
  typedef struct packed {
    logic slotFirst;   // first tick of a memory slot
    logic take;        // request handshake at this edge
    logic takeWrite;   // direction of the taken request
  } schedStrobeS;

endpackage

// File: rtl/sram_sched_ctrl.sv
module sram_sched_ctrl
  import sram_sched_pkg::*;
#(
  parameter int NOP_BASE = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        cfgExtraNop,
  input  logic        tagFull,
  output logic        reqReady,
  output schedStrobeS strobe
);

  localparam int NOP_MAX = NOP_BASE + 1;
  localparam int CW      = $clog2(NOP_MAX + 1);

  logic          phase;      // 0: first tick of slot, 1: second tick
  logic          lastRd;     // most recent command was a read
  logic [CW-1:0] idleSlots;  // idle slots since then (saturating)
  logic [CW-1:0] needSlots;
  logic          turnOk;
  logic          take;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  always_comb begin
    needSlots = cfgExtraNop ? CW'(NOP_MAX) : CW'(NOP_BASE);
    turnOk    = !lastRd || (idleSlots >= needSlots);
    reqReady  = phase && !tagFull && (!reqWrite || turnOk);
    take      = reqValid && reqReady;
  end

  // the slot decision is made in the second tick of each slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRd    <= 1'b0;
      idleSlots <= '0;
    end else if (phase) begin
      if (take) begin
        lastRd    <= !reqWrite;
        idleSlots <= '0;
      end else if (idleSlots != CW'(NOP_MAX)) begin
        idleSlots <= idleSlots + 1'b1;
      end
    end
  end

  assign strobe.slotFirst = !phase;
  assign strobe.take      = take;
  assign strobe.takeWrite = reqWrite;

endmodule

// File: rtl/sram_sched_tagq.sv
module sram_sched_tagq #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushTag,
  input  logic         pop,
  output logic [W-1:0] headTag,
  output logic         full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= pushTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign headTag = slots[rdPtr];
  assign full    = (count == CW'(DEPTH));

endmodule

// File: rtl/sram_sched_datapath.sv
module sram_sched_datapath
  import sram_sched_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 18,
  parameter int TAG_W     = 4,
  parameter int TAG_DEPTH = 4,
  parameter int LAT_NORM  = 5,
  parameter int LAT_SLOW  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  schedStrobeS         strobe,
  input  logic                cfgSlowLat,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*DATA_W-1:0] reqWdata,
  input  logic [TAG_W-1:0]    reqTag,
  output logic [1:0]          memCmd,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWdataValid,
  output logic                rdEarly,
  output logic                rdValid,
  output logic                rdLast,
  output logic [TAG_W-1:0]    rdTag,
  output logic                tagFull
);

  localparam int SR_LEN = LAT_NORM + 1;

  memCmdE              cmdQ;
  logic [ADDR_W-1:0]   addrQ;
  logic [2*DATA_W-1:0] wdataQ;
  logic [SR_LEN-1:0]   retSr;    // read flight tracker, one bit per tick
  logic                issueRd;
  logic                wordFirst, wordLast;

  // command registers load at the end of every slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= CMD_NOP;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (!strobe.slotFirst) begin
      if (strobe.take) begin
        cmdQ   <= strobe.takeWrite ? CMD_WR : CMD_RD;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end else begin
        cmdQ <= CMD_NOP;
      end
    end
  end

  assign memCmd        = cmdQ;
  assign memAddr       = addrQ;
  assign memWdataValid = (cmdQ == CMD_WR);
  assign memWdata      = strobe.slotFirst ? wdataQ[DATA_W-1:0] : wdataQ[2*DATA_W-1:DATA_W];

  assign issueRd = (cmdQ == CMD_RD) && strobe.slotFirst;

  always_ff @(posedge clk) begin
    if (!rstN) retSr <= '0;
    else       retSr <= {retSr[SR_LEN-2:0], issueRd};
  end

  // tap the tracker at the selected latency
  always_comb begin
    if (cfgSlowLat) begin
      rdEarly   = retSr[LAT_SLOW-2];
      wordFirst = retSr[LAT_SLOW-1];
      wordLast  = retSr[LAT_SLOW];
    end else begin
      rdEarly   = retSr[LAT_NORM-2];
      wordFirst = retSr[LAT_NORM-1];
      wordLast  = retSr[LAT_NORM];
    end
  end

  assign rdValid = wordFirst || wordLast;
  assign rdLast  = wordLast;

  sram_sched_tagq #(
    .W    (TAG_W),
    .DEPTH(TAG_DEPTH)
  ) u_tagq (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobe.take && !strobe.takeWrite),
    .pushTag(reqTag),
    .pop    (wordLast),
    .headTag(rdTag),
    .full   (tagFull)
  );

endmodule

// File: rtl/sram_burst_sched.sv
module sram_burst_sched
  import sram_sched_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 18,
  parameter int TAG_W     = 4,
  parameter int TAG_DEPTH = 4,
  parameter int NOP_BASE  = 2,
  parameter int LAT_NORM  = 5,
  parameter int LAT_SLOW  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgExtraNop,
  input  logic                cfgSlowLat,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*DATA_W-1:0] reqWdata,
  input  logic [TAG_W-1:0]    reqTag,
  output logic [1:0]          memCmd,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWdataValid,
  output logic                rdEarly,
  output logic                rdValid,
  output logic                rdLast,
  output logic [TAG_W-1:0]    rdTag
);

  schedStrobeS strobe;
  logic        tagFull;
  logic        slotFirst;

  assign slotFirst = strobe.slotFirst;

  sram_sched_ctrl #(
    .NOP_BASE(NOP_BASE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .cfgExtraNop(cfgExtraNop),
    .tagFull    (tagFull),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  sram_sched_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W),
    .TAG_DEPTH(TAG_DEPTH),
    .LAT_NORM (LAT_NORM),
    .LAT_SLOW (LAT_SLOW)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgSlowLat   (cfgSlowLat),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .reqTag       (reqTag),
    .memCmd       (memCmd),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memWdataValid(memWdataValid),
    .rdEarly      (rdEarly),
    .rdValid      (rdValid),
    .rdLast       (rdLast),
    .rdTag        (rdTag),
    .tagFull      (tagFull)
  );

endmodule

// File: rtl/sram_sched_checker.sv
module sram_sched_checker #(
  parameter int TAG_DEPTH = 4,
  parameter int NOP_BASE  = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       slotFirst,
  input logic       reqReady,
  input logic [1:0] memCmd,
  input logic       rdEarly,
  input logic       rdValid,
  input logic       rdLast,
  input logic       cfgExtraNop,
  input logic       cfgSlowLat
);

  localparam int OW = $clog2(TAG_DEPTH + 1) + 1;

  logic [2:0]    gapSlots;  // idle slots seen since the last read slot
  logic          rdSeen;
  logic [OW-1:0] outst;     // reads shown on the bus and not yet finished

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapSlots <= '0;
      rdSeen   <= 1'b0;
      outst    <= '0;
    end else begin
      if (slotFirst) begin
        case (memCmd)
          2'd1:    begin gapSlots <= '0; rdSeen <= 1'b1; end
          2'd2:    rdSeen <= 1'b0;
          default: if (gapSlots != 3'd7) gapSlots <= gapSlots + 1'b1;
        endcase
      end
      outst <= outst + OW'(slotFirst && memCmd == 2'd1) - OW'(rdLast);
    end
  end

  p_ready_second_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !slotFirst);

  p_cmd_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    !slotFirst |-> $stable(memCmd));

  p_turnaround_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slotFirst && memCmd == 2'd2 && rdSeen) |->
      (int'(gapSlots) >= (cfgExtraNop ? NOP_BASE + 1 : NOP_BASE)));

  p_cfg_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({cfgExtraNop, cfgSlowLat}) |-> ($past(outst) == '0));

  p_early_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdLast) |-> $past(rdEarly));

  p_last_after_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> $past(rdValid && !rdLast));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (outst < OW'(TAG_DEPTH)));

  p_outst_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    outst <= OW'(TAG_DEPTH));

  p_reset_idle_r10: assert property (@(posedge clk)
    !rstN |=> (memCmd == 2'd0 && !rdValid && !reqReady));

endmodule

bind sram_burst_sched sram_sched_checker #(
  .TAG_DEPTH(TAG_DEPTH),
  .NOP_BASE (NOP_BASE)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .slotFirst  (slotFirst),
  .reqReady   (reqReady),
  .memCmd     (memCmd),
  .rdEarly    (rdEarly),
  .rdValid    (rdValid),
  .rdLast     (rdLast),
  .cfgExtraNop(cfgExtraNop),
  .cfgSlowLat (cfgSlowLat)
);

// File: tb/sram_burst_sched_bench.sv
module sram_burst_sched_bench;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int LAT_N = 5;
  localparam int LAT_S = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgExtraNop = 1'b0;
  logic          cfgSlowLat = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [2*DW-1:0] reqWdata = '0;
  logic [TW-1:0] reqTag = '0;
  logic [1:0]    memCmd;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memWdataValid;
  logic          rdEarly, rdValid, rdLast;
  logic [TW-1:0] rdTag;

  always #4 clk = ~clk;

  sram_burst_sched #(
    .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .TAG_DEPTH(2)
  ) u_sram_burst_sched (
    .clk(clk), .rstN(rstN), .cfgExtraNop(cfgExtraNop), .cfgSlowLat(cfgSlowLat),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqTag(reqTag),
    .memCmd(memCmd), .memAddr(memAddr), .memWdata(memWdata),
    .memWdataValid(memWdataValid), .rdEarly(rdEarly), .rdValid(rdValid),
    .rdLast(rdLast), .rdTag(rdTag)
  );

  int tickCnt = 0;
  always @(posedge clk) tickCnt <= tickCnt + 1;

  int vectors = 0;
  int miscompares = 0;
  int lastIssue = 0;
  bit slowMode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]      cmd;
    logic [AW-1:0]   addr;
    logic [2*DW-1:0] data;
    int              tick;
  } cmdExpT;

  typedef struct {
    logic [TW-1:0] tag;
    int            first;
  } rdExpT;

  cmdExpT cmdExp[$];
  rdExpT  rdExp[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: offer one request, wait for the handshake, record expectations
  task automatic sendReq(input bit wr, input logic [AW-1:0] a,
                         input logic [2*DW-1:0] d, input logic [TW-1:0] t);
    cmdExpT c;
    rdExpT  r;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqTag = t;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    lastIssue = tickCnt;
    c.cmd = wr ? 2'd2 : 2'd1; c.addr = a; c.data = d; c.tick = tickCnt;
    cmdExp.push_back(c);
    if (!wr) begin
      r.tag = t;
      r.first = tickCnt + (slowMode ? LAT_S : LAT_N);
      rdExp.push_back(r);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // command bus monitor (R1, R3, R4)
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (cmdExp.size() > 0 && tickCnt == cmdExp[0].tick) begin
        check("R1", "command in first tick", int'(memCmd), int'(cmdExp[0].cmd));
        check("R1", "address", int'(memAddr), int'(cmdExp[0].addr));
        if (cmdExp[0].cmd == 2'd2) begin
          check("R4", "write valid first tick", int'(memWdataValid), 1);
          check("R4", "first write word", int'(memWdata), int'(cmdExp[0].data[DW-1:0]));
        end
      end else if (cmdExp.size() > 0 && tickCnt == cmdExp[0].tick + 1) begin
        check("R1", "command held second tick", int'(memCmd), int'(cmdExp[0].cmd));
        if (cmdExp[0].cmd == 2'd2) begin
          check("R4", "write valid second tick", int'(memWdataValid), 1);
          check("R4", "second write word", int'(memWdata), int'(cmdExp[0].data[2*DW-1:DW]));
        end
        void'(cmdExp.pop_front());
      end else begin
        check("R1", "idle slot command", int'(memCmd), 0);
      end
    end
  end

  // read return scoreboard (R5..R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rdEarly) begin
        automatic int idx = (rdValid && rdLast) ? 1 : 0;
        if (rdExp.size() > idx) check("R7", "early flag tick", tickCnt, rdExp[idx].first - 1);
        else                    check("R7", "unexpected early flag", 1, 0);
      end
      if (rdValid) begin
        if (rdExp.size() == 0) begin
          check("R8", "unexpected read word", 1, 0);
        end else begin
          check(slowMode ? "R6" : "R5", "read word tick", tickCnt,
                rdExp[0].first + (rdLast ? 1 : 0));
          check("R8", "read tag", int'(rdTag), int'(rdExp[0].tag));
          if (rdLast) void'(rdExp.pop_front());
        end
      end else if (rdExp.size() > 0 && tickCnt > rdExp[0].first) begin
        check(slowMode ? "R6" : "R5", "missing read word", tickCnt, rdExp[0].first);
        void'(rdExp.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (4) @(negedge clk);
    check("R10", "memCmd in reset", int'(memCmd), 0);
    check("R10", "rdValid in reset", int'(rdValid), 0);
    check("R10", "reqReady in reset", int'(reqReady), 0);
    rstN = 1'b1;

    // normal latency, two-slot bubble
    sendReq(1'b1, 12'h010, 16'hA55A, 4'd0); g = lastIssue;
    sendReq(1'b1, 12'h011, 16'h1234, 4'd0);
    check("R3", "write after write gap", lastIssue - g, 2); g = lastIssue;
    sendReq(1'b0, 12'h010, 16'h0, 4'd1);
    check("R3", "read after write gap", lastIssue - g, 2); g = lastIssue;
    sendReq(1'b0, 12'h011, 16'h0, 4'd2);
    check("R3", "read after read gap", lastIssue - g, 2); g = lastIssue;
    sendReq(1'b1, 12'h020, 16'hBEEF, 4'd0);
    check("R2", "write after read gap", lastIssue - g, 6); g = lastIssue;
    sendReq(1'b0, 12'h020, 16'h0, 4'd3);
    check("R3", "read after write gap", lastIssue - g, 2); g = lastIssue;
    sendReq(1'b0, 12'h021, 16'h0, 4'd4);
    check("R3", "read after read gap", lastIssue - g, 2);
    repeat (20) @(negedge clk);

    // three-slot bubble
    cfgExtraNop = 1'b1;
    repeat (2) @(negedge clk);
    sendReq(1'b0, 12'h030, 16'h0, 4'd5); g = lastIssue;
    sendReq(1'b1, 12'h031, 16'hC3C3, 4'd0);
    check("R2", "extra bubble gap", lastIssue - g, 8); g = lastIssue;
    sendReq(1'b1, 12'h032, 16'h0F0F, 4'd0);
    check("R3", "write after write gap", lastIssue - g, 2);
    repeat (20) @(negedge clk);

    // one-cycle latency mode
    cfgExtraNop = 1'b0; cfgSlowLat = 1'b1; slowMode = 1'b1;
    repeat (2) @(negedge clk);
    sendReq(1'b0, 12'h040, 16'h0, 4'd6); g = lastIssue;
    sendReq(1'b0, 12'h041, 16'h0, 4'd7);
    check("R6", "read after read gap", lastIssue - g, 2); g = lastIssue;
    sendReq(1'b1, 12'h042, 16'h5AA5, 4'd0);
    check("R2", "write after read gap slow", lastIssue - g, 6); g = lastIssue;
    sendReq(1'b0, 12'h043, 16'h0, 4'd8);
    check("R3", "read after write gap", lastIssue - g, 2);
    repeat (20) @(negedge clk);

    // tag store of depth 2 fills
    cfgSlowLat = 1'b0; slowMode = 1'b0;
    repeat (2) @(negedge clk);
    sendReq(1'b0, 12'h050, 16'h0, 4'd9); g = lastIssue;
    sendReq(1'b0, 12'h051, 16'h0, 4'd10);
    check("R9", "second read gap", lastIssue - g, 2); g = lastIssue;
    sendReq(1'b0, 12'h052, 16'h0, 4'd11);
    check("R9", "read stalled by full tag store", lastIssue - g, 6);
    repeat (20) @(negedge clk);

    check("R8", "reads left unreturned", rdExp.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule